// File: doc/BRIEF.md
# Byte-to-Nibble Stream Expander

The block takes in a byte stream and sends each byte back out as two bytes. The low four bits of the input go out first and the high four bits go out second. In each output byte the nibble sits in the low half and the upper half is zero. Input and output run on one clock and are paced by a single periodic strobe. A new byte can be offered on every strobe, but an output byte can only leave on a strobe too, so the block can emit just one input byte for every two strobes. A synchronous FIFO holds accepted bytes until they can be emitted. When the FIFO is full, `in_ready` goes low and a sticky overflow flag records any byte that had to be dropped.

Emission is controlled by a two-state nibble-phase machine. The states are:
- `PH_LOW`: the next emission is the low nibble of the FIFO head.
- `PH_HIGH`: the next emission is the high nibble of the FIFO head.

It has two transitions:
- `LOW_SENT` moves `PH_LOW` to `PH_HIGH`. It happens on a strobe while the FIFO is non-empty.
- `HIGH_SENT` moves `PH_HIGH` back to `PH_LOW`. It happens on a strobe while the FIFO is non-empty, and it also pops the head.

With the FIFO empty, the machine stays in `PH_LOW`.

Top module: `nibble_expander`

## Requirements
- R1: After a synchronous active-high reset, the outputs are as follows: `out_valid`=0, `out_data`=0x00, `in_ready`=1 and `overflow`=0. The FIFO is empty and the next emission is a low nibble.
- R2: A byte is accepted only on a cycle where `stb`, `in_valid` and `in_ready` are all 1. When `stb` is 0, `in_valid` and `in_data` have no effect.
- R3: The first output byte for an input byte is {4'h0, in[3:0]}. For example, 0xD5 gives 0x05.
- R4: The second output byte for the same input is {4'h0, in[7:4]}. For example, 0xD5 gives 0x0D. The input byte leaves the FIFO only after this byte has been sent.
- R5: Bytes come out in the order they were accepted. Both nibbles of one byte are sent before any nibble of the next. For example, D5 5A 02 gives 05 0D 0A 05 02 00.
- R6: `out_valid` is 1 exactly on `stb` cycles when the FIFO holds at least one byte. Whenever `out_valid` is 0, `out_data` is 0x00.
- R7: `in_ready` is 0 while the FIFO holds DEPTH bytes. A byte offered with `stb`=1 and `in_valid`=1 in that state is dropped, and `overflow` goes to 1 on the next cycle. This applies even if the head is popped on the same strobe.
- R8: Once `overflow` is 1, it stays 1 until reset.
- R9: Outputs are computed from the FIFO contents before the current strobe. A byte accepted into an empty FIFO therefore appears no earlier than the following strobe. A push and a pop on the same strobe both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | Periodic pacing strobe for both input and output |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | FIFO has space |
| out_valid | output | 1 | Nibble byte emitted this cycle |
| out_data | output | 8 | Zero-extended nibble, 0x00 when not valid |
| overflow | output | 1 | Sticky: a byte was dropped |

## Verification
Two things can happen on the same strobe: a new byte is accepted, and the high-nibble emission pops the FIFO head. The bench causes this by offering a byte on every strobe in long runs, and also in random bursts, so that strobes where a push and a pop coincide keep recurring both with the FIFO partly filled and with it full. A behavioural queue model predicts every cycle. Its full test uses the occupancy before the strobe, so the overlap is judged by two things. First, the occupancy stays steady across a push-and-pop strobe. Second, a byte offered while full is dropped even though a pop happens on that same strobe, and this shows up as a missing pair in the emitted sequence and as `overflow` going high.

// File: rtl/nibx_pkg.sv
package nibx_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } nib_phase_t;
endpackage

// File: rtl/nibx_fifo.sv
module nibx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] count;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/nibx_phase_fsm.sv
module nibx_phase_fsm
    import nibx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic         empty,
    input  logic [W-1:0] head,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         pop
);
    localparam int HALF = W / 2;

    nib_phase_t state, state_nxt;
    logic emit;

    assign emit = stb && !empty;

    always_ff @(posedge clk) begin
        if (rst) state <= PH_LOW;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_LOW:  if (emit) state_nxt = PH_HIGH;
            PH_HIGH: if (emit) state_nxt = PH_LOW;
            default: state_nxt = PH_LOW;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        pop       = 1'b0;
        unique case (state)
            PH_LOW: begin
                if (emit) begin
                    out_valid = 1'b1;
                    out_data  = {{(W-HALF){1'b0}}, head[HALF-1:0]};
                end
            end
            PH_HIGH: begin
                if (emit) begin
                    out_valid = 1'b1;
                    out_data  = {{HALF{1'b0}}, head[W-1:HALF]};
                    pop       = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nibx_overflow.sv
module nibx_overflow (
    input  logic clk,
    input  logic rst,
    input  logic offer,
    input  logic full,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)                flag <= 1'b0;
        else if (offer && full) flag <= 1'b1;
    end
endmodule

// File: rtl/nibble_expander.sv
module nibble_expander #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         overflow
);
    logic         full_w, empty_w, pop_w, push_w, offer_w;
    logic [W-1:0] head_w;

    assign offer_w  = stb && in_valid;
    assign push_w   = offer_w && !full_w;
    assign in_ready = !full_w;

    nibx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push_w), .pop(pop_w),
        .din(in_data), .dout(head_w), .full(full_w), .empty(empty_w)
    );

    nibx_phase_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst(rst), .stb(stb), .empty(empty_w), .head(head_w),
        .out_valid(out_valid), .out_data(out_data), .pop(pop_w)
    );

    nibx_overflow u_ovf (
        .clk(clk), .rst(rst), .offer(offer_w), .full(full_w), .flag(overflow)
    );
endmodule

// File: rtl/nibble_expander_chk.sv
module nibble_expander_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         stb,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         overflow,
    input logic         pop
);
    // R6
    emit_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> stb);
    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));
    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[W-1:W/2] == '0));
    // R4
    pop_after_emit_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> out_valid);
    // R7
    drop_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && in_valid && !in_ready) |=> overflow);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind nibble_expander nibble_expander_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .stb(stb), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow), .pop(pop_w)
);

// File: tb/nibble_expander_bench.sv
module nibble_expander_bench;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, overflow;
    logic [7:0] out_data;

    int total = 0;
    int fails = 0;

    logic [7:0] q[$];
    logic [7:0] got[$];
    bit         ph = 1'b0;
    bit         ovf = 1'b0;
    int         slot = 0;

    always #4 clk = ~clk;

    nibble_expander #(.W(8), .DEPTH(DEPTH)) u_nibble_expander (
        .clk(clk), .rst(rst), .stb(stb), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .overflow(overflow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // one cycle: drive at negedge, compare against the model, advance the model
    task automatic step(input bit s, input bit v, input logic [7:0] d);
        bit         e_valid;
        logic [7:0] e_data;
        int         sz;
        @(negedge clk);
        stb = s; in_valid = v; in_data = d;
        #1;
        sz      = q.size();
        e_valid = s && (sz > 0);
        e_data  = 8'h00;
        if (e_valid) e_data = ph ? {4'h0, q[0][7:4]} : {4'h0, q[0][3:0]};
        check(out_valid == e_valid, "R6 out_valid", out_valid, e_valid);
        check(out_data == e_data, ph ? "R4 high nibble" : "R3 low nibble", out_data, e_data);
        check(in_ready == (sz < DEPTH), "R7 in_ready", in_ready, sz < DEPTH);
        check(overflow == ovf, "R8 overflow", overflow, ovf);
        if (out_valid) got.push_back(out_data);
        if (e_valid) begin
            if (ph) void'(q.pop_front());
            ph = !ph;
        end
        if (s && v) begin
            if (sz < DEPTH) q.push_back(d);
            else ovf = 1'b1;
        end
    endtask

    // strobe every fifth cycle (40 ns at 8 ns clock)
    task automatic tick(input bit v, input logic [7:0] d);
        bit s;
        s = (slot % 5) == 0;
        slot++;
        step(s, s ? v : (v && d[0]), d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; stb = 0; in_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete(); got.delete(); ph = 0; ovf = 0; slot = 0;
        #1;
        check(out_valid == 0 && out_data == 0, "R1 outputs idle", {out_valid, out_data}, 0);
        check(in_ready == 1 && overflow == 0, "R1 ready/flag", {in_ready, overflow}, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL R5 watchdog: act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R9: first byte into empty FIFO not emitted on its own strobe
        step(1, 1, 8'hD5);
        check(out_valid == 0, "R9 same-strobe emit", out_valid, 0);
        // R2: valid without strobe is ignored
        step(0, 1, 8'hFF);
        step(0, 1, 8'hEE);
        step(1, 1, 8'h5A);
        step(0, 0, 8'h00);
        step(1, 1, 8'h02);
        for (int i = 0; i < 12; i++) step((i % 2) == 0, 0, 8'h00);
        check(got.size() == 6, "R2 output count", got.size(), 6);
        if (got.size() == 6) begin
            check(got[0] == 8'h05 && got[1] == 8'h0D, "R5 seq byte0", {got[0], got[1]}, 16'h050D);
            check(got[2] == 8'h0A && got[3] == 8'h05, "R5 seq byte1", {got[2], got[3]}, 16'h0A05);
            check(got[4] == 8'h02 && got[5] == 8'h00, "R5 seq byte2", {got[4], got[5]}, 16'h0200);
        end

        // R7: continuous input on every strobe overflows the FIFO
        do_reset();
        for (int i = 0; i < 200; i++) tick(1, 8'(i * 7 + 3));
        check(in_ready == 0 || q.size() == DEPTH, "R7 reaches full", in_ready, 0);
        check(overflow == 1, "R7 drop flagged", overflow, 1);
        // drain; R8 flag stays
        for (int i = 0; i < 250; i++) tick(0, 8'h00);
        check(overflow == 1, "R8 sticky after drain", overflow, 1);
        check(q.size() == 0 && in_ready == 1, "R9 drained", in_ready, 1);

        // random bursts and gaps
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            bit v;
            v = ((i / 60) % 2 == 0) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 5) == 0);
            tick(v, 8'($urandom));
        end
        for (int i = 0; i < 250; i++) tick(0, 8'h00);

        do_reset();
        check(overflow == 0, "R1 flag cleared", overflow, 0);

        summary();
        $finish;
    end
endmodule